// File: doc/BRIEF.md
# Channel-Status Lock Qualifier for an IEC 958 Receiver

This block sits behind an IEC 958 biphase decoder that has already recovered frames. For each frame it is given a strobe, the channel-status bit of the first subframe, a flag that marks the first frame of a 192-frame block, and the decoder's own lock signal. It gathers one channel-status block and decodes a small set of fields from it: the audio/non-audio flag, the pre-emphasis code, the sample-rate code and the clock-accuracy code. From these it derives three signals for the audio path. The first is a lock that is true only for a validated PCM stream. The second is a de-emphasis enable with a rate select. The third is a mute request. The decoded fields are also presented as a packed status word for a control interface to read.

A control-path input can suppress the automatic mute, so the audio path keeps running while the decoder is out of lock.

The collector is a three-state machine. `ST_IDLE` holds while raw lock is low. `ST_HUNT` waits for a block-start frame. `ST_COLLECT` counts frames through one block. The machine has these transitions:
- idle→hunt when raw lock rises.
- hunt→collect on a block-start frame.
- collect→collect on a block-start frame that arrives early, which restarts the count.
- collect→hunt after the 192nd frame, which also commits the block.
- any state→idle when raw lock falls.

Top module: `cs_lock_qualifier`

## Requirements
- R1: The frame strobed together with `block_start` supplies channel-status bit 0. Each later strobed frame supplies the next bit. When bit 191 arrives, the captured fields are committed together. A `block_start` that arrives before bit 191 discards the partial block and restarts counting at bit 0.
- R2: When the committed channel-status bit 1 is 1 (non-PCM), `lock_q` is low even though `raw_lock` is high.
- R3: `status_word` has the following layout. Bits [15:12] are 0.
  - [0] `lock_q`
  - [1] PCM indication (fields valid and bit 1 = 0)
  - [2] fields valid
  - [5:3] channel-status bits 3..5, with bit 3 at [3]
  - [9:6] rate code, channel-status bits 24..27, with bit 24 at [6]
  - [11:10] channel-status bits 28..29, with bit 28 at [10]
  
  After reset the whole word is 0.
- R4: `mute_req` is high whenever `lock_q` is low and `mute_override` is low. `mute_req` is low whenever `lock_q` is high.
- R5: While `mute_override` is high, `mute_req` is low even when `lock_q` is low.
- R6: `deemph_en` is high only under three conditions together. First, `lock_q` is high. Second, pre-emphasis is flagged: channel-status bit 3 = 1 and bits 4 and 5 = 0. Third, the rate code (bit 24 as LSB) is one of 4'b0000 (44.1 kHz), 4'b0010 (48 kHz) or 4'b0011 (32 kHz). Any other code leaves it low.
- R7: `deemph_rate` is 2'b01 for 32 kHz, 2'b10 for 44.1 kHz and 2'b11 for 48 kHz while `deemph_en` is high. It is 2'b00 while `deemph_en` is low.
- R8: Fields become valid only after a complete block has been received while `raw_lock` stays high. When `raw_lock` falls, `lock_q` drops in the same cycle and the valid flag clears on the next edge. A block that was already under way when lock returned never validates.
- R9: The clock edge that samples bit 191 is the first edge. The committed fields and the derived outputs change after the second edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_lock | input | 1 | Lock from the biphase decoder |
| frame_valid | input | 1 | One-cycle strobe per received frame |
| cs_bit | input | 1 | Channel-status bit of the first subframe |
| block_start | input | 1 | Marks the first frame of a block, qualified by `frame_valid` |
| mute_override | input | 1 | Control bit that suppresses automatic mute |
| lock_q | output | 1 | Qualified lock: raw lock, valid fields, PCM |
| mute_req | output | 1 | Mute request for the analog and data outputs |
| deemph_en | output | 1 | De-emphasis enable |
| deemph_rate | output | 2 | De-emphasis rate select |
| status_word | output | 16 | Packed decoded status |

## Verification
A collector whose frame counter has slipped commits a block one frame early or late. The shifted rate and pre-emphasis bits then reach `status_word` and `deemph_rate` two edges after the mis-timed final frame. The latency check at the bit-191 boundary catches this case. If the state machine fails to leave the collect state when lock is lost, a partial block after relock validates stale fields. `lock_q` and `mute_req` would show this directly, in the cycle after the resumed block ends. A stuck valid flag shows as `status_word[2]` still high one cycle after `raw_lock` falls.

// File: rtl/cslq_pkg.sv
package cslq_pkg;

    localparam int BLOCK_BITS = 192;
    localparam int CAP_W      = 32;
    localparam int STATUS_W   = 16;

    localparam int NONPCM_POS = 1;
    localparam int PRE_LSB    = 3;
    localparam int FS_LSB     = 24;
    localparam int ACC_LSB    = 28;

    localparam logic [2:0] PRE_FLAGGED = 3'b001;
    localparam logic [3:0] FS_44K1     = 4'b0000;
    localparam logic [3:0] FS_48K      = 4'b0010;
    localparam logic [3:0] FS_32K      = 4'b0011;

    localparam logic [1:0] RATE_NONE = 2'b00;
    localparam logic [1:0] RATE_32   = 2'b01;
    localparam logic [1:0] RATE_44   = 2'b10;
    localparam logic [1:0] RATE_48   = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HUNT    = 2'd1,
        ST_COLLECT = 2'd2
    } cslq_state_e;

    typedef struct packed {
        logic       non_pcm;
        logic [2:0] preemph;
        logic [3:0] fs_code;
        logic [1:0] clk_acc;
    } cs_fields_t;

endpackage

// File: rtl/cslq_collector.sv
module cslq_collector
    import cslq_pkg::*;
#(
    parameter int NBITS = BLOCK_BITS,
    parameter int CAPW  = CAP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_lock,
    input  logic            frame_valid,
    input  logic            cs_bit,
    input  logic            block_start,
    output logic [CAPW-1:0] cap,
    output logic            commit
);

    localparam int CNT_W  = $clog2(NBITS + 1);
    localparam int CAP_IW = $clog2(CAPW);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBITS - 1);
    localparam logic [CNT_W-1:0] CAP_LIM  = CNT_W'(CAPW);

    cslq_state_e      state, state_d;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic             take_bit;
    logic             last_bit;

    // bit position of the current frame: restart on block start
    always_comb begin
        idx      = block_start ? '0 : cnt;
        take_bit = 1'b0;
        unique case (state)
            ST_IDLE:    take_bit = 1'b0;
            ST_HUNT:    take_bit = raw_lock && frame_valid && block_start;
            ST_COLLECT: take_bit = raw_lock && frame_valid;
            default:    take_bit = 1'b0;
        endcase
        last_bit = (state == ST_COLLECT) && take_bit && !block_start
                   && (cnt == LAST_IDX);
    end

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (raw_lock) state_d = ST_HUNT;
            end
            ST_HUNT: begin
                if (!raw_lock)                        state_d = ST_IDLE;
                else if (frame_valid && block_start)  state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (!raw_lock)     state_d = ST_IDLE;
                else if (last_bit) state_d = ST_HUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // data path and commit pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            cap    <= '0;
            commit <= 1'b0;
        end else begin
            commit <= last_bit;
            if (take_bit) begin
                cnt <= idx + 1'b1;
                if (idx < CAP_LIM) cap[idx[CAP_IW-1:0]] <= cs_bit;
            end else if (state_d != ST_COLLECT) begin
                cnt <= '0;
            end
        end
    end

    p_commit_from_collect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(state == ST_COLLECT && raw_lock));

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(NBITS));

    p_idle_on_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_lock |=> state == ST_IDLE);

endmodule

// File: rtl/cslq_fields.sv
module cslq_fields
    import cslq_pkg::*;
#(
    parameter int CAPW = CAP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_lock,
    input  logic            commit,
    input  logic [CAPW-1:0] cap,
    output cs_fields_t      fields,
    output logic            fields_valid
);

    cs_fields_t decoded;

    always_comb begin
        decoded.non_pcm = cap[NONPCM_POS];
        decoded.preemph = cap[PRE_LSB +: 3];
        decoded.fs_code = cap[FS_LSB +: 4];
        decoded.clk_acc = cap[ACC_LSB +: 2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields       <= '0;
            fields_valid <= 1'b0;
        end else if (!raw_lock) begin
            fields_valid <= 1'b0;
        end else if (commit) begin
            fields       <= decoded;
            fields_valid <= 1'b1;
        end
    end

    p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fields_valid) |-> $past(commit && raw_lock));

    p_fields_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> $stable(fields));

endmodule

// File: rtl/cslq_policy.sv
module cslq_policy
    import cslq_pkg::*;
#(
    parameter int SW = STATUS_W
) (
    input  logic          raw_lock,
    input  logic          fields_valid,
    input  cs_fields_t    fields,
    input  logic          mute_override,
    output logic          lock_q,
    output logic          mute_req,
    output logic          deemph_en,
    output logic [1:0]    deemph_rate,
    output logic [SW-1:0] status_word
);

    logic       pcm_ind;
    logic [1:0] rate_code;

    always_comb begin
        unique case (fields.fs_code)
            FS_32K:  rate_code = RATE_32;
            FS_44K1: rate_code = RATE_44;
            FS_48K:  rate_code = RATE_48;
            default: rate_code = RATE_NONE;
        endcase
    end

    always_comb begin
        pcm_ind     = fields_valid && !fields.non_pcm;
        lock_q      = raw_lock && pcm_ind;
        mute_req    = !lock_q && !mute_override;
        deemph_en   = lock_q && (fields.preemph == PRE_FLAGGED)
                      && (rate_code != RATE_NONE);
        deemph_rate = deemph_en ? rate_code : RATE_NONE;
        status_word          = '0;
        status_word[0]       = lock_q;
        status_word[1]       = pcm_ind;
        status_word[2]       = fields_valid;
        status_word[5:3]     = fields.preemph;
        status_word[9:6]     = fields.fs_code;
        status_word[11:10]   = fields.clk_acc;
    end

endmodule

// File: rtl/cs_lock_qualifier.sv
module cs_lock_qualifier
    import cslq_pkg::*;
#(
    parameter int NBITS = BLOCK_BITS,
    parameter int CAPW  = CAP_W,
    parameter int SW    = STATUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_lock,
    input  logic          frame_valid,
    input  logic          cs_bit,
    input  logic          block_start,
    input  logic          mute_override,
    output logic          lock_q,
    output logic          mute_req,
    output logic          deemph_en,
    output logic [1:0]    deemph_rate,
    output logic [SW-1:0] status_word
);

    logic [CAPW-1:0] cap;
    logic            commit;
    cs_fields_t      fields;
    logic            fields_valid;

    cslq_collector #(.NBITS(NBITS), .CAPW(CAPW)) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_lock    (raw_lock),
        .frame_valid (frame_valid),
        .cs_bit      (cs_bit),
        .block_start (block_start),
        .cap         (cap),
        .commit      (commit)
    );

    cslq_fields #(.CAPW(CAPW)) u_fields (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_lock     (raw_lock),
        .commit       (commit),
        .cap          (cap),
        .fields       (fields),
        .fields_valid (fields_valid)
    );

    cslq_policy #(.SW(SW)) u_policy (
        .raw_lock      (raw_lock),
        .fields_valid  (fields_valid),
        .fields        (fields),
        .mute_override (mute_override),
        .lock_q        (lock_q),
        .mute_req      (mute_req),
        .deemph_en     (deemph_en),
        .deemph_rate   (deemph_rate),
        .status_word   (status_word)
    );

    p_nonpcm_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fields_valid && fields.non_pcm) |-> !lock_q);

    p_lock_needs_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_lock |-> !lock_q);

    p_mute_when_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !mute_override) |-> mute_req);

    p_rate_matches_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        deemph_en == (deemph_rate != 2'b00));

    p_deemph_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        deemph_en |-> (lock_q && fields_valid));

endmodule

// File: tb/cs_lock_qualifier_tb.sv
module cs_lock_qualifier_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_lock = 1'b0;
    logic        frame_valid = 1'b0;
    logic        cs_bit = 1'b0;
    logic        block_start = 1'b0;
    logic        mute_override = 1'b0;
    logic        lock_q, mute_req, deemph_en;
    logic [1:0]  deemph_rate;
    logic [15:0] status_word;

    always #5 clk = ~clk;

    cs_lock_qualifier u_dut (
        .clk(clk), .rst_n(rst_n), .raw_lock(raw_lock),
        .frame_valid(frame_valid), .cs_bit(cs_bit), .block_start(block_start),
        .mute_override(mute_override), .lock_q(lock_q), .mute_req(mute_req),
        .deemph_en(deemph_en), .deemph_rate(deemph_rate),
        .status_word(status_word)
    );

    typedef struct {
        string       tag;
        logic        lock;
        logic        mute;
        logic        den;
        logic [1:0]  rate;
        logic [15:0] stat;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    // reference model state
    logic       m_np = 0, m_valid = 0;
    logic [2:0] m_pre = 0;
    logic [3:0] m_fs = 0;
    logic [1:0] m_acc = 0;

    task automatic check(string tag, string name, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", tag, name, got, exp);
        end
    endtask

    function automatic exp_t model(string tag);
        exp_t       e;
        logic       pcm, pre_on;
        logic [1:0] r;
        pcm    = m_valid && !m_np;
        pre_on = (m_pre == 3'b001);
        case (m_fs)
            4'b0011: r = 2'b01;
            4'b0000: r = 2'b10;
            4'b0010: r = 2'b11;
            default: r = 2'b00;
        endcase
        e.tag  = tag;
        e.lock = raw_lock && pcm;
        e.mute = !e.lock && !mute_override;
        e.den  = e.lock && pre_on && (r != 2'b00);
        e.rate = e.den ? r : 2'b00;
        e.stat = {4'b0, m_acc, m_fs, m_pre, m_valid, pcm, e.lock};
        return e;
    endfunction

    task automatic expect_now(string tag);
        q.push_back(model(tag));
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "lock_q",      16'(lock_q),      16'(e.lock));
                check(e.tag, "mute_req",    16'(mute_req),    16'(e.mute));
                check(e.tag, "deemph_en",   16'(deemph_en),   16'(e.den));
                check(e.tag, "deemph_rate", 16'(deemph_rate), 16'(e.rate));
                check(e.tag, "status_word", status_word,      e.stat);
            end
        end
    end

    function automatic logic [191:0] mk_block(logic np, logic [2:0] pre,
                                              logic [3:0] fs, logic [1:0] acc);
        logic [191:0] b;
        b        = '0;
        b[0]     = 1'b0;
        b[1]     = np;
        b[5:3]   = pre;
        b[27:24] = fs;
        b[29:28] = acc;
        b[100]   = 1'b1;
        return b;
    endfunction

    task automatic send_frame(logic b, logic s);
        @(negedge clk);
        frame_valid = 1'b1;
        cs_bit      = b;
        block_start = s;
        @(negedge clk);
        frame_valid = 1'b0;
        block_start = 1'b0;
    endtask

    task automatic send_bits(logic [191:0] blk, int from, int to, bit with_start);
        for (int i = from; i <= to; i++)
            send_frame(blk[i], (i == from) && with_start);
    endtask

    task automatic full_block(logic np, logic [2:0] pre, logic [3:0] fs,
                              logic [1:0] acc, string tag);
        send_bits(mk_block(np, pre, fs, acc), 0, 191, 1'b1);
        @(negedge clk);
        m_np = np; m_pre = pre; m_fs = fs; m_acc = acc; m_valid = 1'b1;
        @(negedge clk);
        expect_now(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R3_reset");
        raw_lock = 1'b1;
        @(negedge clk);
        expect_now("R8_no_block_yet");

        full_block(0, 3'b001, 4'b0010, 2'b01, "R6_48k_preemph");
        full_block(0, 3'b000, 4'b0000, 2'b00, "R6_44k_no_preemph");
        full_block(0, 3'b001, 4'b0011, 2'b10, "R7_32k");
        full_block(0, 3'b001, 4'b0000, 2'b11, "R7_44k");
        full_block(0, 3'b001, 4'b1010, 2'b01, "R6_unsupported_rate");
        full_block(0, 3'b011, 4'b0010, 2'b00, "R6_other_preemph_code");
        full_block(1, 3'b001, 4'b0010, 2'b00, "R2_nonpcm");

        // R5: override lifts mute while unlocked
        @(negedge clk);
        mute_override = 1'b1;
        expect_now("R5_override_on");
        @(negedge clk);
        mute_override = 1'b0;
        expect_now("R4_override_off");

        // R9: commit latency around the final bit
        full_block(0, 3'b001, 4'b0010, 2'b01, "R1_relock_good");
        begin
            logic [191:0] b;
            b = mk_block(0, 3'b001, 4'b0011, 2'b11);
            send_bits(b, 0, 190, 1'b1);
            expect_now("R9_before_last");
            send_frame(b[191], 1'b0);
            expect_now("R9_one_edge_after");
            @(negedge clk);
            m_fs = 4'b0011; m_acc = 2'b11;
            expect_now("R9_two_edges_after");
        end

        // R8: raw lock lost mid-block
        begin
            logic [191:0] b;
            b = mk_block(0, 3'b001, 4'b0000, 2'b00);
            send_bits(b, 0, 99, 1'b1);
            @(negedge clk);
            raw_lock = 1'b0;
            #1;
            check("R8", "lock_q_same_cycle", 16'(lock_q), 16'h0);
            check("R4", "mute_same_cycle",   16'(mute_req), 16'h1);
            @(negedge clk);
            m_valid = 1'b0;
            expect_now("R8_valid_cleared");
            raw_lock = 1'b1;
            send_bits(b, 100, 191, 1'b0);
            repeat (2) @(negedge clk);
            expect_now("R8_partial_after_relock");
        end
        full_block(0, 3'b001, 4'b0000, 2'b10, "R8_recovered");

        // R1: early block start restarts collection
        send_bits(mk_block(1, 3'b000, 4'b1111, 2'b00), 0, 59, 1'b1);
        full_block(0, 3'b001, 4'b0011, 2'b01, "R1_resync");

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule